// File: doc/BRIEF.md
# Digit-Serial Normal-Basis Field Multiplier

This block multiplies two elements of the binary field GF(2^M) held in normal-basis form. Every result bit comes from one shared product-bit function applied to a rotated copy of the two operands. The block holds DIGIT copies of that function side by side, so each iteration yields DIGIT consecutive result bits. A one-stage pipeline register sits between the function copies and the result register. This keeps the critical path at a single function block whatever the value of DIGIT.

A caller presents both operands with a one-cycle start pulse and gets back an M-bit product with a one-cycle done pulse. The basis is a type-II optimal normal basis. The product-bit function is derived in the design from the field size and the prime 2M+1, so any M that has such a basis can be used. The default field is M = 11 with prime 23. The default digit width is 3, so the last iteration fills only 2 of its 3 lanes.

Top module: `onb_digit_mult`

## Requirements
- R1: Bit i of an operand or of the product is the coefficient of basis element g^(2^i) + g^(-2^i), where g is a primitive (2M+1)-th root of unity. The product equals a*b in GF(2^M) under this basis, and a zero operand gives a zero product.
- R2: The all-ones word is the field unit, so multiplying any a by all-ones returns a.
- R3: With start high at clock edge E0, done is high for the cycle that follows edge E0 + ceil(M/DIGIT) + 1. This is one edge for loading, ceil(M/DIGIT) edges for iterations and one edge for the pipeline stage.
- R4: Squaring moves each coefficient one position toward the higher index: (a*a)[k] = a[k-1], and (a*a)[0] = a[M-1].
- R5: A start pulse during a multiplication is ignored. The running product and its timing are unchanged, and no extra done follows.
- R6: done is high for exactly one cycle per accepted start.
- R7: prod holds its value from done until the next accepted start.
- R8: After reset, done is 0 and prod is all zeros.
- R9: When DIGIT does not divide M, the last iteration writes only the M mod DIGIT remaining bits. The highest product bits are still correct.
- R10: The product is commutative: a*b and b*a give the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request, accepted only while idle |
| a_i | input | M | First operand, normal-basis coefficients |
| b_i | input | M | Second operand, normal-basis coefficients |
| prod_o | output | M | Product, normal-basis coefficients |
| done_o | output | 1 | One-cycle pulse when prod_o is complete |

## Verification
The main function is tried with patterns whose results are known without a reference: zero operands, the all-ones unit, and squaring, which must come out as a one-place rotation. These separate a wrong lane rotation or bit ordering from a wrong basis function. Swapped operand pairs and pseudo-random pairs are compared with a reference that expands each basis-element product into root-of-unity exponents. This shows that the rotated single-function scheme equals the full multiplication matrix, including the high bits written by the partial final digit. Overlapping start pulses and long idle stretches check that the result is held and that requests during a run are dropped.

// File: rtl/onb_mult_pkg.sv
package onb_mult_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } seq_state_e;

  // 2^k reduced modulo p
  function automatic int pow2_mod(input int k, input int p);
    int r;
    r = 1;
    for (int t = 0; t < k; t++) r = (r * 2) % p;
    return r;
  endfunction

  // Does the basis-element product beta_i*beta_j contain beta_0?
  // Sum and difference exponents land on +-1 for beta_0.
  function automatic logic basis_hit(input int i, input int j, input int p);
    int pi, pj, s, d;
    logic hs, hd;
    pi = pow2_mod(i, p);
    pj = pow2_mod(j, p);
    s  = (pi + pj) % p;
    d  = (pi - pj + p) % p;
    hs = (s == 1) || (s == p - 1);
    hd = (d == 1) || (d == p - 1);
    return hs ^ hd;
  endfunction

endpackage

// File: rtl/onb_operand_rot.sv
module onb_operand_rot #(
  parameter int M = 11,
  parameter int D = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic [M-1:0] a_q,
  output logic [M-1:0] b_q
);

  // rotate toward index 0 by D places: new[i] = old[(i+D) mod M]
  function automatic logic [M-1:0] rot_down(input logic [M-1:0] v);
    logic [M-1:0] r;
    for (int i = 0; i < M; i++) r[i] = v[(i + D) % M];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load_i) begin
      a_q <= a_i;
      b_q <= b_i;
    end else if (shift_i) begin
      a_q <= rot_down(a_q);
      b_q <= rot_down(b_q);
    end
  end

  assert_load_excl_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !shift_i)
    else $error("load and shift in the same cycle");

endmodule

// File: rtl/onb_lane_array.sv
module onb_lane_array #(
  parameter int M  = 11,
  parameter int D  = 3,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [M-1:0]  a_q,
  input  logic [M-1:0]  b_q,
  input  logic          fire_i,
  input  logic [CW-1:0] idx_i,
  output logic [D-1:0]  digit_q,
  output logic [CW-1:0] idx_q,
  output logic          vld_q
);
  import onb_mult_pkg::*;

  localparam int P = 2 * M + 1;

  function automatic logic [M-1:0] rot_by(input logic [M-1:0] v, input int n);
    logic [M-1:0] r;
    for (int i = 0; i < M; i++) r[i] = v[(i + n) % M];
    return r;
  endfunction

  // shared product-bit function: coefficient of beta_0 in a*b
  function automatic logic prod_bit(input logic [M-1:0] a, input logic [M-1:0] b);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++)
        if (basis_hit(i, j, P)) acc = acc ^ (a[i] & b[j]);
    return acc;
  endfunction

  logic [D-1:0] lane_bit;

  for (genvar l = 0; l < D; l++) begin : g_lane
    logic [M-1:0] a_l, b_l;
    always_comb begin
      a_l = rot_by(a_q, l);
      b_l = rot_by(b_q, l);
      lane_bit[l] = prod_bit(a_l, b_l);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digit_q <= '0;
      idx_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= fire_i;
      if (fire_i) begin
        digit_q <= lane_bit;
        idx_q   <= idx_i;
      end
    end
  end

  assert_idx_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (int'(idx_q) * D < M))
    else $error("digit index beyond field");

endmodule

// File: rtl/onb_digit_collect.sv
module onb_digit_collect #(
  parameter int M  = 11,
  parameter int D  = 3,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [CW-1:0] idx_i,
  input  logic [D-1:0]  digit_i,
  output logic [M-1:0]  prod_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_o <= '0;
    end else if (vld_i) begin
      for (int l = 0; l < D; l++) begin
        int pos;
        pos = int'(idx_i) * D + l;
        if (pos < M) prod_o[pos] <= digit_i[l];
      end
    end
  end

  assert_prod_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(prod_o))
    else $error("product moved without a digit");

endmodule

// File: rtl/onb_seq_ctrl.sv
module onb_seq_ctrl #(
  parameter int ITER = 4,
  parameter int CW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          load_o,
  output logic          fire_o,
  output logic [CW-1:0] idx_o,
  output logic          done_o
);
  import onb_mult_pkg::*;

  seq_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic          last_iter;

  assign load_o    = start_i && (state_q == ST_IDLE);
  assign fire_o    = (state_q == ST_RUN);
  assign idx_o     = cnt_q;
  assign last_iter = (cnt_q == CW'(ITER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (load_o) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (last_iter) state_q <= ST_FLUSH;
          else           cnt_q   <= cnt_q + 1'b1;
        end
        ST_FLUSH: begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (int'(cnt_q) < ITER))
    else $error("iteration counter out of range");

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("done longer than one cycle");

  assert_run_no_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> (state_q != ST_IDLE))
    else $error("run left without flush");

endmodule

// File: rtl/onb_digit_mult.sv
module onb_digit_mult #(
  parameter int M     = 11,
  parameter int DIGIT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic [M-1:0] prod_o,
  output logic         done_o
);

  localparam int ITER = (M + DIGIT - 1) / DIGIT;
  localparam int CW   = (ITER > 1) ? $clog2(ITER) : 1;

  logic          load_w, fire_w;
  logic [CW-1:0] idx_w, pipe_idx_w;
  logic [M-1:0]  a_rot_w, b_rot_w;
  logic [DIGIT-1:0] pipe_digit_w;
  logic          pipe_vld_w;

  onb_seq_ctrl #(.ITER(ITER), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_o(load_w), .fire_o(fire_w), .idx_o(idx_w), .done_o(done_o)
  );

  onb_operand_rot #(.M(M), .D(DIGIT)) u_rot (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .shift_i(fire_w),
    .a_i(a_i), .b_i(b_i), .a_q(a_rot_w), .b_q(b_rot_w)
  );

  onb_lane_array #(.M(M), .D(DIGIT), .CW(CW)) u_lanes (
    .clk(clk), .rst_n(rst_n), .a_q(a_rot_w), .b_q(b_rot_w),
    .fire_i(fire_w), .idx_i(idx_w),
    .digit_q(pipe_digit_w), .idx_q(pipe_idx_w), .vld_q(pipe_vld_w)
  );

  onb_digit_collect #(.M(M), .D(DIGIT), .CW(CW)) u_collect (
    .clk(clk), .rst_n(rst_n), .vld_i(pipe_vld_w),
    .idx_i(pipe_idx_w), .digit_i(pipe_digit_w), .prod_o(prod_o)
  );

  assert_done_after_digit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(pipe_vld_w))
    else $error("done without a final digit");

  assert_last_digit_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_vld_w && int'(pipe_idx_w) == ITER - 1) |=> done_o)
    else $error("final digit not followed by done");

endmodule

// File: tb/onb_digit_mult_tb.sv
module onb_digit_mult_tb_top;

  localparam int M     = 11;
  localparam int DIGIT = 3;
  localparam int P     = 2 * M + 1;
  localparam int LAT   = (M + DIGIT - 1) / DIGIT + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [M-1:0] a_i = '0, b_i = '0;
  logic [M-1:0] prod_o;
  logic         done_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  onb_digit_mult #(.M(M), .DIGIT(DIGIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .a_i(a_i), .b_i(b_i), .prod_o(prod_o), .done_o(done_o)
  );

  function automatic int pw(input int k);
    int r = 1;
    for (int t = 0; t < k; t++) r = (r * 2) % P;
    return r;
  endfunction

  // basis element whose exponent class contains e (zero when e == 0)
  function automatic logic [M-1:0] term(input int e);
    logic [M-1:0] v = '0;
    for (int k = 0; k < M; k++)
      if (e != 0 && (pw(k) == e || P - pw(k) == e)) v[k] = 1'b1;
    return v;
  endfunction

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] c = '0;
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++)
        if (a[i] && b[j]) begin
          c = c ^ term((pw(i) + pw(j)) % P);
          c = c ^ term((pw(i) - pw(j) + P) % P);
        end
    return c;
  endfunction

  task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_mul(input logic [M-1:0] a, input logic [M-1:0] b,
                         output logic [M-1:0] p, output int lat);
    @(negedge clk);
    a_i = a; b_i = b; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    for (int n = 0; n < 20; n++) begin
      if (done_o) break;
      @(posedge clk); lat++;
      @(negedge clk);
    end
    p = prod_o;
  endtask

  task automatic t_reset();
    check("R8 prod after reset", prod_o, '0);
    check_int("R8 done after reset", int'(done_o), 0);
  endtask

  task automatic t_zero();
    logic [M-1:0] p; int lat;
    run_mul('0, 11'h5a3, p, lat);
    check("R1 zero operand", p, '0);
    check_int("R3 latency", lat, LAT);
  endtask

  task automatic t_unit();
    logic [M-1:0] p; int lat;
    run_mul(11'h2c9, '1, p, lat);
    check("R2 unit right", p, 11'h2c9);
    run_mul('1, 11'h013, p, lat);
    check("R2 unit left", p, 11'h013);
  endtask

  task automatic t_square();
    logic [M-1:0] p, a; int lat;
    a = 11'h481;
    run_mul(a, a, p, lat);
    check("R4 square rotates", p, {a[M-2:0], a[M-1]});
    a = 11'h001;
    run_mul(a, a, p, lat);
    check("R4 square single bit", p, 11'h002);
  endtask

  task automatic t_random();
    logic [M-1:0] p, q, a, b; int lat;
    for (int n = 0; n < 12; n++) begin
      a = M'($urandom); b = M'($urandom);
      run_mul(a, b, p, lat);
      check("R1 R9 product vs reference", p, ref_mul(a, b));
      check_int("R3 latency", lat, LAT);
      run_mul(b, a, q, lat);
      check("R10 commutative", q, p);
    end
  endtask

  task automatic t_busy_start();
    logic [M-1:0] a1, b1; int lat; bit extra;
    a1 = 11'h6b5; b1 = 11'h31e;
    @(negedge clk);
    a_i = a1; b_i = b1; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0; lat = 0;
    for (int n = 0; n < 20; n++) begin
      if (done_o) break;
      if (lat == 2) begin a_i = 11'h7ff; b_i = 11'h155; start_i = 1'b1; end
      else start_i = 1'b0;
      @(posedge clk); lat++;
      @(negedge clk);
    end
    start_i = 1'b0;
    check_int("R5 latency with stray start", lat, LAT);
    check("R5 product with stray start", prod_o, ref_mul(a1, b1));
    @(posedge clk); @(negedge clk);
    check_int("R6 done one cycle", int'(done_o), 0);
    extra = 0;
    for (int n = 0; n < 10; n++) begin
      @(posedge clk); @(negedge clk);
      if (done_o) extra = 1;
    end
    check_int("R5 no second done", int'(extra), 0);
    check("R7 product held", prod_o, ref_mul(a1, b1));
  endtask

  task automatic t_hold();
    logic [M-1:0] p; int lat;
    run_mul(11'h0f0, 11'h333, p, lat);
    @(negedge clk);
    a_i = '1; b_i = '1;
    for (int n = 0; n < 8; n++) begin @(posedge clk); @(negedge clk); end
    check("R7 hold while inputs change", prod_o, p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_zero();
    t_unit();
    t_square();
    t_random();
    t_busy_start();
    t_hold();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule